// File: doc/BRIEF.md
# Command-Queue I2C Master Sequencer

This block drives an I2C master from a queue of command words. Each word pairs a three-bit opcode with an eight-bit operand. The sequencer pops words from an external command FIFO and turns each into one or more byte-level bus operations on an internal byte engine. Received bytes go into an external receive FIFO, and three one-cycle event pulses report a completed stop, a NACK and a lost arbitration.

A single receive word carries a byte count, so one word can move up to 256 bytes with no help from software. The sequencer picks the acknowledge bit for each received byte on its own. It stalls with the clock held low whenever it has nothing to do while it owns the bus. Two options change its behaviour. With auto-stop set, it closes the transfer by itself once the queue runs dry. With ignore-NACK set, it carries on through slave NACKs.

The byte engine is a simple timing model. It takes a fixed number of cycles per byte and samples the slave's acknowledge, read data and arbitration inputs at the end of each byte. Every operation it starts appears on the bus observation ports.

Top module: `cmdq_i2c_sequencer`

## Requirements
- R1: A command word holds its opcode in bits 10:8 and its operand in bits 7:0. Opcode 0 pops one word and launches one transmit operation (bus op code 2) whose byte equals the operand.
- R2: Opcodes 4 and 6 launch a start operation (bus op code 1) that carries the operand as the address. Opcode 6 also raises hs_mode from the end of that start until a stop completes.
- R3: Opcode 1 with operand n launches n+1 receive operations (bus op code 3). Each received byte is pushed on rx_push in order. Opcode 3 launches the same operations but pushes nothing.
- R4: Every received byte except the last of a receive word is acknowledged (bus_mack=0). The last byte is NACKed (bus_mack=1) when, at its launch, the command FIFO is empty or its head holds opcode 2, 4, 5, 6 or 7. Otherwise the last byte is acknowledged.
- R5: Opcode 2 launches a stop operation (bus op code 4). Its completion pulses stop_done for one cycle, and from then on scl_hold and hs_mode are low.
- R6: When the slave NACKs an address or a transmitted byte (slv_ack=0 at the end of the byte), nack_evt pulses and no further word is popped until nack_clear. Opcodes 5 and 7 reverse the expectation, so for them an acknowledge raises nack_evt and a NACK does not.
- R7: With cfg_auto_stop set, a stop operation is launched when the sequencer owns the bus and either the command FIFO is empty or the sequencer is halted. With cfg_auto_stop clear, the bus stays held (scl_hold=1) and no stop is launched.
- R8: With cfg_ignore_nack set, a slave NACK raises no event and does not stop the sequencer from popping words.
- R9: While rx_full is high, no receive operation of opcode 1 is launched and scl_hold stays high. The transfer resumes when rx_full falls, and no byte is lost.
- R10: Arbitration lost (arb_lost_in high at the end of a start or transmit) pulses arb_lost and releases the bus without a stop operation (scl_hold=0). It also halts popping until nack_clear.
- R11: During reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command FIFO not empty |
| cmd_word | input | 11 | Command FIFO head word |
| cmd_pop | output | 1 | Pops the head word this cycle |
| rx_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Writes rx_data into the receive FIFO |
| rx_data | output | 8 | Received byte |
| cfg_auto_stop | input | 1 | Stop automatically when the queue runs dry or on halt |
| cfg_ignore_nack | input | 1 | Carry on through slave NACKs |
| nack_clear | input | 1 | Leaves the halted state |
| slv_ack | input | 1 | Slave acknowledge (1 = ACK), sampled at the end of a byte |
| slv_rdata | input | 8 | Slave read data, sampled at the end of a byte |
| arb_lost_in | input | 1 | Arbitration lost indication from the bus |
| bus_go | output | 1 | A byte engine operation starts this cycle |
| bus_op | output | 3 | Operation: 1 start, 2 transmit, 3 receive, 4 stop |
| bus_byte | output | 8 | Address or transmit byte of the operation |
| bus_mack | output | 1 | Master acknowledge for a receive (1 = NACK) |
| scl_hold | output | 1 | Bus owned and waiting, clock held low |
| hs_mode | output | 1 | High-speed start in effect |
| stop_done | output | 1 | Stop completed pulse |
| nack_evt | output | 1 | Unexpected acknowledge response pulse |
| arb_lost | output | 1 | Arbitration lost pulse |

## Verification
Two things happen in the same cycle when the last byte of a receive word starts: its acknowledge bit is chosen, and the command FIFO head is examined. The bench provokes this by queuing a whole transfer in a single cycle, so the word after each receive is already at the head when the last byte starts. Receives are followed by transmit, start and stop words and by an empty queue. The bench judges the outcome from the bus_mack value logged with each receive operation, compared against a bench model that walks the same word list.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

   typedef enum logic [2:0] {
      CMD_TX        = 3'd0,
      CMD_RX        = 3'd1,
      CMD_STOP      = 3'd2,
      CMD_RXDROP    = 3'd3,
      CMD_START     = 3'd4,
      CMD_START_NK  = 3'd5,
      CMD_HSTART    = 3'd6,
      CMD_HSTART_NK = 3'd7
   } cmd_op_e;

   typedef enum logic [2:0] {
      BUS_NONE  = 3'd0,
      BUS_START = 3'd1,
      BUS_TX    = 3'd2,
      BUS_RX    = 3'd3,
      BUS_STOP  = 3'd4
   } bus_op_e;

endpackage

// File: rtl/i2cs_cmd_decode.sv
module i2cs_cmd_decode
   import i2cs_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OPC_W  = 3,
   localparam int CMD_W = DATA_W + OPC_W
) (
   input  logic [CMD_W-1:0]  word_i,
   output cmd_op_e           opc_o,
   output logic [DATA_W-1:0] data_o,
   output logic              is_start_o,
   output logic              is_stop_o,
   output logic              is_rx_o,
   output logic              store_o,
   output logic              exp_nack_o,
   output logic              hs_o
);

   generate
      if (OPC_W != 3) begin : g_bad_opc
         $error("i2cs_cmd_decode: OPC_W must be 3");
      end
   endgenerate

   always_comb begin
      opc_o      = cmd_op_e'(word_i[DATA_W +: OPC_W]);
      data_o     = word_i[DATA_W-1:0];
      is_start_o = word_i[DATA_W+2];
      is_stop_o  = (opc_o == CMD_STOP);
      is_rx_o    = (opc_o == CMD_RX) || (opc_o == CMD_RXDROP);
      store_o    = (opc_o == CMD_RX);
      exp_nack_o = (opc_o == CMD_START_NK) || (opc_o == CMD_HSTART_NK);
      hs_o       = (opc_o == CMD_HSTART) || (opc_o == CMD_HSTART_NK);
   end

endmodule

// File: rtl/i2cs_byte_engine.sv
module i2cs_byte_engine
   import i2cs_pkg::*;
#(
   parameter int BYTE_CYCLES = 4,
   parameter int DATA_W      = 8,
   localparam int CW         = (BYTE_CYCLES > 1) ? $clog2(BYTE_CYCLES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  bus_op_e           op_i,
   input  logic              slv_ack_i,
   input  logic [DATA_W-1:0] slv_rdata_i,
   input  logic              arb_i,
   output logic              busy_o,
   output logic              done_o,
   output bus_op_e           op_o,
   output logic              sack_o,
   output logic              arb_o,
   output logic [DATA_W-1:0] rdata_o
);

   generate
      if (BYTE_CYCLES < 2) begin : g_bad_len
         $error("i2cs_byte_engine: BYTE_CYCLES must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o  <= 1'b0;
         done_o  <= 1'b0;
         op_o    <= BUS_NONE;
         sack_o  <= 1'b0;
         arb_o   <= 1'b0;
         rdata_o <= '0;
         cnt_q   <= '0;
      end else begin
         done_o <= 1'b0;
         if (go_i) begin
            busy_o <= 1'b1;
            op_o   <= op_i;
            cnt_q  <= CW'(BYTE_CYCLES - 1);
         end else if (busy_o) begin
            if (cnt_q == '0) begin
               busy_o  <= 1'b0;
               done_o  <= 1'b1;
               sack_o  <= slv_ack_i;
               arb_o   <= arb_i && ((op_o == BUS_START) || (op_o == BUS_TX));
               rdata_o <= slv_rdata_i;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   // a new byte may only start on an idle engine
   assert_go_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      go_i |-> (!busy_o && !done_o));

endmodule

// File: rtl/cmdq_i2c_sequencer.sv
module cmdq_i2c_sequencer
   import i2cs_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OPC_W       = 3,
   parameter int BYTE_CYCLES = 4,
   localparam int CMD_W      = DATA_W + OPC_W,
   localparam int RLW        = DATA_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [CMD_W-1:0]  cmd_word,
   output logic              cmd_pop,
   input  logic              rx_full,
   output logic              rx_push,
   output logic [DATA_W-1:0] rx_data,
   input  logic              cfg_auto_stop,
   input  logic              cfg_ignore_nack,
   input  logic              nack_clear,
   input  logic              slv_ack,
   input  logic [DATA_W-1:0] slv_rdata,
   input  logic              arb_lost_in,
   output logic              bus_go,
   output logic [2:0]        bus_op,
   output logic [DATA_W-1:0] bus_byte,
   output logic              bus_mack,
   output logic              scl_hold,
   output logic              hs_mode,
   output logic              stop_done,
   output logic              nack_evt,
   output logic              arb_lost
);

   // head-of-queue decode
   cmd_op_e           d_opc;
   logic [DATA_W-1:0] d_data;
   logic              d_start, d_stop, d_rx, d_store, d_expnk, d_hs;

   i2cs_cmd_decode #(.DATA_W(DATA_W), .OPC_W(OPC_W)) u_dec (
      .word_i     (cmd_word),
      .opc_o      (d_opc),
      .data_o     (d_data),
      .is_start_o (d_start),
      .is_stop_o  (d_stop),
      .is_rx_o    (d_rx),
      .store_o    (d_store),
      .exp_nack_o (d_expnk),
      .hs_o       (d_hs)
   );

   // byte engine
   logic              e_busy, e_done, e_sack, e_arb;
   bus_op_e           e_op;
   logic [DATA_W-1:0] e_rdata;
   logic              launch;
   bus_op_e           lop;

   i2cs_byte_engine #(.BYTE_CYCLES(BYTE_CYCLES), .DATA_W(DATA_W)) u_eng (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_i        (launch),
      .op_i        (lop),
      .slv_ack_i   (slv_ack),
      .slv_rdata_i (slv_rdata),
      .arb_i       (arb_lost_in),
      .busy_o      (e_busy),
      .done_o      (e_done),
      .op_o        (e_op),
      .sack_o      (e_sack),
      .arb_o       (e_arb),
      .rdata_o     (e_rdata)
   );

   // sequencer state
   logic           owned_q, halted_q, hs_q, hs_pend_q, expnk_q, store_q, wait_q;
   logic [RLW-1:0] rx_left_q;
   logic           stop_q, nack_q, arb_q, push_q;
   logic [DATA_W-1:0] rdata_q;
   logic           last_nack, pop;
   logic [DATA_W-1:0] lbyte;
   logic           lmack;

   assign last_nack = !cmd_valid || d_stop || d_start;

   always_comb begin
      launch = 1'b0;
      lop    = BUS_NONE;
      lbyte  = '0;
      lmack  = 1'b0;
      pop    = 1'b0;
      if (!wait_q) begin
         if (rx_left_q != '0) begin
            if (!(store_q && rx_full)) begin
               launch = 1'b1;
               lop    = BUS_RX;
               lmack  = (rx_left_q == RLW'(1)) && last_nack;
            end
         end else if (halted_q) begin
            if (owned_q && cfg_auto_stop) begin
               launch = 1'b1;
               lop    = BUS_STOP;
            end
         end else if (cmd_valid) begin
            pop = 1'b1;
            if (d_start) begin
               launch = 1'b1;
               lop    = BUS_START;
               lbyte  = d_data;
            end else if (d_opc == CMD_TX) begin
               launch = 1'b1;
               lop    = BUS_TX;
               lbyte  = d_data;
            end else if (d_stop) begin
               launch = 1'b1;
               lop    = BUS_STOP;
            end
         end else if (owned_q && cfg_auto_stop) begin
            launch = 1'b1;
            lop    = BUS_STOP;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owned_q   <= 1'b0;
         halted_q  <= 1'b0;
         hs_q      <= 1'b0;
         hs_pend_q <= 1'b0;
         expnk_q   <= 1'b0;
         store_q   <= 1'b0;
         wait_q    <= 1'b0;
         rx_left_q <= '0;
         stop_q    <= 1'b0;
         nack_q    <= 1'b0;
         arb_q     <= 1'b0;
         push_q    <= 1'b0;
         rdata_q   <= '0;
      end else begin
         stop_q <= 1'b0;
         nack_q <= 1'b0;
         arb_q  <= 1'b0;
         push_q <= 1'b0;
         if (nack_clear) halted_q <= 1'b0;
         if (pop && d_rx) begin
            rx_left_q <= RLW'(d_data) + RLW'(1);
            store_q   <= d_store;
         end
         if (pop && d_start) begin
            expnk_q   <= d_expnk;
            hs_pend_q <= d_hs;
         end
         if (launch) begin
            wait_q <= 1'b1;
            if (lop == BUS_RX) rx_left_q <= rx_left_q - RLW'(1);
         end
         if (e_done) begin
            wait_q <= 1'b0;
            unique case (e_op)
               BUS_START, BUS_TX: begin
                  if (e_arb) begin
                     arb_q    <= 1'b1;
                     owned_q  <= 1'b0;
                     hs_q     <= 1'b0;
                     halted_q <= 1'b1;
                  end else begin
                     if (e_op == BUS_START) begin
                        owned_q <= 1'b1;
                        hs_q    <= hs_pend_q;
                     end
                     if (((e_op == BUS_START) ? (e_sack == expnk_q) : !e_sack)
                         && !cfg_ignore_nack) begin
                        nack_q   <= 1'b1;
                        halted_q <= 1'b1;
                     end
                  end
               end
               BUS_RX: begin
                  if (store_q) begin
                     push_q  <= 1'b1;
                     rdata_q <= e_rdata;
                  end
               end
               BUS_STOP: begin
                  stop_q  <= 1'b1;
                  owned_q <= 1'b0;
                  hs_q    <= 1'b0;
               end
               default: ;
            endcase
         end
      end
   end

   assign cmd_pop   = pop;
   assign bus_go    = launch;
   assign bus_op    = lop;
   assign bus_byte  = lbyte;
   assign bus_mack  = lmack;
   assign scl_hold  = owned_q && !wait_q;
   assign hs_mode   = hs_q;
   assign stop_done = stop_q;
   assign nack_evt  = nack_q;
   assign arb_lost  = arb_q;
   assign rx_push   = push_q;
   assign rx_data   = rdata_q;

   assert_halt_blocks_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (nack_evt && !nack_clear) |=> !cmd_pop);

   assert_no_store_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_go && (bus_op == 3'(BUS_RX)) && store_q) |-> !rx_full);

   assert_stop_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stop_done |-> (!scl_hold && !hs_mode));

   assert_events_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stop_done, nack_evt, arb_lost}));

   assert_arb_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost |-> !scl_hold);

   assert_ignore_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_ignore_nack && $past(cfg_ignore_nack)) |-> !nack_evt);

endmodule

// File: tb/tb_cmdq_i2c_sequencer.sv
module tb_cmdq_i2c_sequencer;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid, cmd_pop, rx_full, rx_push;
   logic [10:0] cmd_word;
   logic [7:0]  rx_data, slv_rdata, bus_byte;
   logic        cfg_auto_stop, cfg_ignore_nack, nack_clear, slv_ack, arb_lost_in;
   logic        bus_go, bus_mack, scl_hold, hs_mode, stop_done, nack_evt, arb_lost;
   logic [2:0]  bus_op;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmdq_i2c_sequencer dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
      .cmd_pop(cmd_pop), .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
      .cfg_auto_stop(cfg_auto_stop), .cfg_ignore_nack(cfg_ignore_nack),
      .nack_clear(nack_clear), .slv_ack(slv_ack), .slv_rdata(slv_rdata),
      .arb_lost_in(arb_lost_in), .bus_go(bus_go), .bus_op(bus_op),
      .bus_byte(bus_byte), .bus_mack(bus_mack), .scl_hold(scl_hold),
      .hs_mode(hs_mode), .stop_done(stop_done), .nack_evt(nack_evt),
      .arb_lost(arb_lost));

   // command FIFO model
   logic [10:0] cmdq [64];
   logic [7:0]  wr_ptr = '0, rd_ptr = '0;
   assign cmd_valid = (wr_ptr != rd_ptr);
   assign cmd_word  = cmdq[rd_ptr[5:0]];

   int rx_seen = 0;
   function automatic logic [7:0] gen(int k);
      return 8'((k * 37 + 5) & 255);
   endfunction
   assign slv_rdata = gen(rx_seen);

   // observation logs
   int log_op [64], log_byte [64], log_mack [64], rcv [64];
   int nlog = 0, nrcv = 0, nstop = 0, nnack = 0, narb = 0;
   bit hs_seen = 0;

   initial forever begin
      @(posedge clk);
      if (rst_n) begin
         if (cmd_pop) rd_ptr <= rd_ptr + 8'd1;
         if (bus_go) begin
            if (nlog < 64) begin
               log_op[nlog] = int'(bus_op); log_byte[nlog] = int'(bus_byte);
               log_mack[nlog] = int'(bus_mack);
            end
            nlog++;
            if (bus_op == 3'd3) rx_seen <= rx_seen + 1;
         end
         if (rx_push) begin
            if (nrcv < 64) rcv[nrcv] = int'(rx_data);
            nrcv++;
         end
         if (stop_done) nstop++;
         if (nack_evt) nnack++;
         if (arb_lost) narb++;
         if (hs_mode) hs_seen = 1;
      end
   end

   // checking
   int nchk = 0, nfail = 0;
   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // expected-value model
   logic [10:0] wl [16];
   int wn;
   int exp_op [64], exp_byte [64], exp_mack [64], exp_rx [64];
   int nexp, nexprx;

   task automatic add_exp(input int op, input int b, input int m);
      exp_op[nexp] = op; exp_byte[nexp] = b; exp_mack[nexp] = m; nexp++;
   endtask

   task automatic model(input bit auto_stop, input int base);
      bit owned = 0;
      int rxk = 0;
      nexp = 0; nexprx = 0;
      for (int i = 0; i < wn; i++) begin
         int op = int'(wl[i][10:8]);
         int d  = int'(wl[i][7:0]);
         if (op == 0) add_exp(2, d, 0);
         else if (op >= 4) begin add_exp(1, d, 0); owned = 1; end
         else if (op == 2) begin add_exp(4, 0, 0); owned = 0; end
         else begin
            for (int j = 0; j <= d; j++) begin
               int nk = 0;
               if (j == d) begin
                  if (i + 1 >= wn) nk = 1;
                  else begin
                     int nop = int'(wl[i+1][10:8]);
                     nk = (nop == 2 || nop >= 4) ? 1 : 0;
                  end
               end
               add_exp(3, 0, nk);
               rxk++;
               if (op == 1) begin exp_rx[nexprx] = int'(gen(base + rxk)); nexprx++; end
            end
         end
      end
      if (owned && auto_stop) add_exp(4, 0, 0);
   endtask

   task automatic clear_logs();
      nlog = 0; nrcv = 0; nstop = 0; nnack = 0; narb = 0; hs_seen = 0;
   endtask

   task automatic push_all();
      for (int i = 0; i < wn; i++) begin
         cmdq[wr_ptr[5:0]] = wl[i];
         wr_ptr = wr_ptr + 8'd1;
      end
   endtask

   task automatic wait_idle();
      int quiet = 0;
      int guard = 0;
      while (quiet < 20 && guard < 5000) begin
         @(negedge clk);
         guard++;
         if (bus_go || cmd_pop) quiet = 0; else quiet++;
      end
   endtask

   task automatic check_log(input string req);
      chk(nlog == nexp, req, "operation count", nlog, nexp);
      for (int i = 0; i < nexp && i < nlog; i++)
         chk(log_op[i] == exp_op[i] && log_byte[i] == exp_byte[i] && log_mack[i] == exp_mack[i],
             req, $sformatf("op %0d {op,byte,mack}", i),
             log_op[i] * 1000 + log_byte[i] * 2 + log_mack[i],
             exp_op[i] * 1000 + exp_byte[i] * 2 + exp_mack[i]);
      chk(nrcv == nexprx, "R3", "stored byte count", nrcv, nexprx);
      for (int i = 0; i < nexprx && i < nrcv; i++)
         chk(rcv[i] == exp_rx[i], "R3", $sformatf("stored byte %0d", i), rcv[i], exp_rx[i]);
   endtask

   task automatic do_reset(input bit auto_s, input bit ign);
      @(negedge clk);
      rst_n = 1'b0;
      wr_ptr = rd_ptr;
      cfg_auto_stop = auto_s; cfg_ignore_nack = ign;
      nack_clear = 0; slv_ack = 1; arb_lost_in = 0; rx_full = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      clear_logs();
   endtask

   task automatic run(input bit auto_s, input string req);
      int base;
      clear_logs();
      base = rx_seen;
      model(auto_s, base);
      push_all();
      wait_idle();
      check_log(req);
   endtask

   bit done_flag = 0;

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         nchk++; nfail++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin
      int sd;
      sd = int'($urandom(32'd4242));
      cfg_auto_stop = 1; cfg_ignore_nack = 0; nack_clear = 0;
      slv_ack = 1; arb_lost_in = 0; rx_full = 0;
      repeat (2) @(negedge clk);
      // R11 reset state
      chk({cmd_pop, rx_push, bus_go, scl_hold, hs_mode, stop_done, nack_evt, arb_lost} == 8'd0,
          "R11", "outputs in reset",
          int'({cmd_pop, rx_push, bus_go, scl_hold, hs_mode, stop_done, nack_evt, arb_lost}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R5: high-speed start, transmit, stop, auto-stop off
      do_reset(0, 0);
      wn = 3; wl[0] = {3'd6, 8'h12}; wl[1] = {3'd0, 8'h34}; wl[2] = {3'd2, 8'h00};
      run(0, "R2");
      chk(hs_seen, "R2", "hs_mode seen", int'(hs_seen), 1);
      chk(nstop == 1 && !hs_mode && !scl_hold, "R5", "stop completion", nstop, 1);

      // R4: last-byte acknowledge against each head kind
      do_reset(1, 0);
      wn = 8;
      wl[0] = {3'd4, 8'h51}; wl[1] = {3'd1, 8'h01}; wl[2] = {3'd0, 8'h55};
      wl[3] = {3'd4, 8'h51}; wl[4] = {3'd3, 8'h00}; wl[5] = {3'd2, 8'h00};
      wl[6] = {3'd4, 8'h51}; wl[7] = {3'd1, 8'h02};
      run(1, "R4");

      // R7: auto-stop off holds the bus
      do_reset(0, 0);
      wn = 2; wl[0] = {3'd4, 8'h22}; wl[1] = {3'd0, 8'h99};
      clear_logs(); push_all(); wait_idle();
      chk(scl_hold && nstop == 0 && nlog == 2, "R7", "bus held without stop", nlog * 10 + nstop, 20);
      wn = 1; wl[0] = {3'd2, 8'h00}; push_all(); wait_idle();
      chk(nstop == 1 && !scl_hold, "R5", "explicit stop releases", nstop, 1);

      // R6: slave NACK halts popping, auto-stop closes
      do_reset(1, 0);
      slv_ack = 0;
      wn = 3; wl[0] = {3'd4, 8'h40}; wl[1] = {3'd0, 8'h11}; wl[2] = {3'd2, 8'h00};
      clear_logs(); push_all(); wait_idle();
      chk(nnack == 1, "R6", "nack event count", nnack, 1);
      chk(nlog == 2 && log_op[1] == 4, "R7", "auto stop after halt", nlog * 10 + log_op[1], 24);
      chk(cmd_valid == 1'b1, "R6", "words left in queue", int'(cmd_valid), 1);
      slv_ack = 1;
      nack_clear = 1; @(negedge clk); nack_clear = 0;
      wait_idle();
      chk(cmd_valid == 1'b0, "R6", "queue drained after clear", int'(cmd_valid), 0);

      // R6: expect-NACK start
      do_reset(1, 0);
      slv_ack = 0;
      wn = 2; wl[0] = {3'd5, 8'h40}; wl[1] = {3'd2, 8'h00};
      clear_logs(); push_all(); wait_idle();
      chk(nnack == 0 && nstop == 1, "R6", "expected NACK is quiet", nnack, 0);
      slv_ack = 1;
      clear_logs(); push_all(); wait_idle();
      chk(nnack == 1, "R6", "unexpected ACK raises event", nnack, 1);

      // R8: ignore NACK
      do_reset(1, 1);
      slv_ack = 0;
      wn = 3; wl[0] = {3'd4, 8'h40}; wl[1] = {3'd0, 8'h11}; wl[2] = {3'd2, 8'h00};
      clear_logs(); push_all(); wait_idle();
      chk(nnack == 0 && nlog == 3 && !cmd_valid, "R8", "ignored NACK", nnack * 10 + nlog, 3);

      // R9: receive FIFO full stalls
      do_reset(1, 0);
      rx_full = 1;
      wn = 3; wl[0] = {3'd4, 8'h61}; wl[1] = {3'd1, 8'h02}; wl[2] = {3'd2, 8'h00};
      clear_logs(); model(1, rx_seen); push_all(); wait_idle();
      chk(nlog == 1 && scl_hold && nrcv == 0, "R9", "stalled on full", nlog * 10 + nrcv, 10);
      rx_full = 0;
      wait_idle();
      check_log("R9");

      // R10: arbitration lost
      do_reset(1, 0);
      arb_lost_in = 1;
      wn = 3; wl[0] = {3'd4, 8'h70}; wl[1] = {3'd0, 8'h01}; wl[2] = {3'd2, 8'h00};
      clear_logs(); push_all(); wait_idle();
      chk(narb == 1 && nlog == 1 && !scl_hold && cmd_valid, "R10", "arbitration lost",
          narb * 10 + nlog, 11);

      // R1 R3 R4: random transfers
      do_reset(1, 0);
      for (int it = 0; it < 30; it++) begin
         wn = 0;
         wl[wn] = {3'd4, 8'($urandom)}; wn++;
         for (int t = 0; t < int'($urandom % 4); t++) begin wl[wn] = {3'd0, 8'($urandom)}; wn++; end
         if ($urandom % 2 == 1) begin
            wl[wn] = {(($urandom % 2 == 1) ? 3'd1 : 3'd3), 8'($urandom % 5)}; wn++;
         end
         if ($urandom % 2 == 1) begin
            wl[wn] = {3'd4, 8'($urandom)}; wn++;
            wl[wn] = {3'd1, 8'($urandom % 5)}; wn++;
         end
         if ($urandom % 2 == 1) begin wl[wn] = {3'd2, 8'h00}; wn++; end
         run(1, "R1");
      end

      done_flag = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule